// File: doc/BRIEF.md
# Keypad Matrix Scanner with Event Queue

This block scans a key matrix of eight drive lines by eight sense lines. It also watches eight special-function keys that are wired straight to their own inputs. The drive lines are pulled low one at a time. After a programmable settle time, the block samples the eight sense lines one per clock. Once every column is done, it samples the function inputs the same way, and then the scan starts over. Each key has its own stable state and its own debounce counter. A change is accepted only after the new level has been seen on a programmed number of consecutive scans.

Each accepted change becomes one byte. Bit 7 is 1 for a press and 0 for a release, and the low seven bits are the key number. The byte goes into a 16-entry first-word-fall-through queue that a host drains one byte at a time. Two sticky error flags go to an interrupt unit: one for an event lost to a full queue, and one for a press refused because too many keys are already held. The non-empty flag serves as the keypad-activity indication.

Top module: `keypad_scan_top`

## Requirements
- R1: `col_o` is active-low with at most one bit low. Each scan drives column 0 through 7 in turn, then holds all bits high for the function-key group. Every group lasts `dwell_i`+9 clocks.
- R2: A press produces byte `{1'b1, key}`. For a matrix key, key = column*8 + row, where the row is the bit of `row_i` that is pulled low.
- R3: A change is accepted on the `debounce_i`-th consecutive scan that sees the new level. A level that returns to the stable state earlier restarts the count and produces no event.
- R4: A release produces byte `{1'b0, key}` after the same debounce rule.
- R5: `evt_o` shows the oldest queued byte, and `evt_valid_o` is high when the queue is not empty. A one-clock `rd_i` removes that byte. `rd_i` on an empty queue has no effect.
- R6: Events found in one scan enter the queue in ascending key order, and the queue keeps arrival order.
- R7: The queue holds 16 bytes. An event that arrives while the queue is full and not being read is dropped, `fifo_ovr_o` sets, and the stored bytes are left unchanged. The key's stable state still follows the accepted change.
- R8: A press that would make more than 8 keys held at once is refused. No event is produced and `key_ovr_o` sets. The press is tried again on each later scan and is accepted once a held key has been released earlier in that scan.
- R9: Both error flags stay set until `err_clr_i` is high for a clock. A new error in the same clock wins over the clear.
- R10: After reset, `col_o` is 8'hFE, the queue is empty, both flags are low and no key is held.
- R11: Function key s (bit s of `sf_i`, active-low) has key number 64+s. It is sampled whatever level `col_o` has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dwell_i | input | 4 | Extra settle clocks per column group |
| debounce_i | input | 4 | Consecutive scans needed to accept a change (0 acts as 1) |
| row_i | input | 8 | Matrix sense lines, low when a key on the driven column is down |
| sf_i | input | 8 | Function-key inputs, active low |
| col_o | output | 8 | Matrix drive lines, active low, one-hot |
| rd_i | input | 1 | Remove the head byte |
| err_clr_i | input | 1 | Clear both error flags |
| evt_o | output | 8 | Head event byte |
| evt_valid_o | output | 1 | Queue not empty |
| fifo_ovr_o | output | 1 | Sticky: event lost to a full queue |
| key_ovr_o | output | 1 | Sticky: press refused, too many keys held |

## Verification
A corrupted per-key stable bit or debounce count does not show up at once. It appears at that key's next evaluation, at most one scan of 9*(`dwell_i`+9) clocks later, as a missing, doubled or early event byte. A wrong held-key count appears only when the ninth press is tried, as `key_ovr_o` firing or not firing in that scan. Queue pointer faults appear on the next `rd_i` as a byte out of order, or as `evt_valid_o` ending too soon or too late. The bench aligns its stimulus to the start of a scan and counts scans, so these effects are caught at the exact scan where they should appear.

// File: rtl/kps_pkg.sv
package kps_pkg;
  typedef enum logic {PH_SETTLE, PH_EVAL} scan_ph_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/kps_scan_seq.sv
module kps_scan_seq
  import kps_pkg::*;
#(
  parameter int unsigned COLS    = 8,
  parameter int unsigned ROWS    = 8,
  parameter int unsigned SF      = 8,
  parameter int unsigned DWELL_W = 4,
  localparam int unsigned GRP_W  = $clog2(COLS + 1),
  localparam int unsigned IDX_W  = $clog2(max_u(ROWS, SF))
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DWELL_W-1:0] dwell_i,
  output logic [COLS-1:0]    col_no,
  output logic               eval_o,
  output logic               is_sf_o,
  output logic [GRP_W-1:0]   grp_o,
  output logic [IDX_W-1:0]   idx_o
);
  scan_ph_e           ph_q;
  logic [GRP_W-1:0]   grp_q;
  logic [IDX_W-1:0]   idx_q;
  logic [DWELL_W-1:0] tmr_q;
  logic               is_sf;
  logic [IDX_W-1:0]   last_idx;

  assign is_sf    = (grp_q == GRP_W'(COLS));
  assign last_idx = is_sf ? IDX_W'(SF - 1) : IDX_W'(ROWS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_SETTLE;
      grp_q <= '0;
      idx_q <= '0;
      tmr_q <= '0;
    end else begin
      case (ph_q)
        PH_SETTLE: begin
          if (tmr_q >= dwell_i) begin
            ph_q  <= PH_EVAL;
            tmr_q <= '0;
            idx_q <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: begin
          if (idx_q == last_idx) begin
            ph_q  <= PH_SETTLE;
            idx_q <= '0;
            grp_q <= is_sf ? '0 : grp_q + 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      endcase
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_no[c] = (grp_q != GRP_W'(c));
  end

  assign eval_o  = (ph_q == PH_EVAL);
  assign is_sf_o = is_sf;
  assign grp_o   = grp_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/kps_debounce.sv
module kps_debounce #(
  parameter int unsigned N_KEYS   = 72,
  parameter int unsigned DEB_W    = 4,
  parameter int unsigned MAX_DOWN = 8,
  localparam int unsigned KEY_W   = $clog2(N_KEYS),
  localparam int unsigned DN_W    = $clog2(N_KEYS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eval_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             raw_i,
  input  logic [DEB_W-1:0] deb_i,
  output logic             push_o,
  output logic [KEY_W:0]   evt_o,
  output logic             refuse_o
);
  logic [N_KEYS-1:0] stable_q;
  logic [DEB_W-1:0]  cnt_q [N_KEYS];
  logic [DN_W-1:0]   down_q;
  logic [DEB_W-1:0]  deb_eff;
  logic [DEB_W:0]    cnt_nx;
  logic              changed, ripe, blocked, accept;

  assign deb_eff = (deb_i == '0) ? DEB_W'(1) : deb_i;
  assign changed = eval_i && (raw_i != stable_q[key_i]);
  assign cnt_nx  = {1'b0, cnt_q[key_i]} + 1'b1;
  assign ripe    = changed && (cnt_nx >= {1'b0, deb_eff});
  // a press is refused while the held-key budget is used up
  assign blocked = ripe && raw_i && (down_q == DN_W'(MAX_DOWN));
  assign accept  = ripe && !blocked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stable_q <= '0;
      down_q   <= '0;
      for (int k = 0; k < N_KEYS; k++) cnt_q[k] <= '0;
    end else if (eval_i) begin
      if (!changed) begin
        cnt_q[key_i] <= '0;
      end else if (accept) begin
        stable_q[key_i] <= raw_i;
        cnt_q[key_i]    <= '0;
        down_q          <= raw_i ? down_q + 1'b1 : down_q - 1'b1;
      end else if (!ripe) begin
        cnt_q[key_i] <= cnt_nx[DEB_W-1:0];
      end
    end
  end

  assign push_o   = accept;
  assign evt_o    = {raw_i, key_i};
  assign refuse_o = blocked;
endmodule

// File: rtl/kps_evt_fifo.sv
module kps_evt_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         drop_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_pop, do_push;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign drop_o  = push_i && full_o && !do_pop;

  function automatic logic [AW-1:0] inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= inc(wp_q);
      if (do_pop)  rp_q <= inc(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end

  assign dout_o = mem_q[rp_q];
endmodule

// File: rtl/keypad_scan_top.sv
module keypad_scan_top
  import kps_pkg::*;
#(
  parameter int unsigned COLS     = 8,
  parameter int unsigned ROWS     = 8,
  parameter int unsigned SF       = 8,
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned DWELL_W  = 4,
  parameter int unsigned DEB_W    = 4,
  parameter int unsigned MAX_DOWN = 8,
  localparam int unsigned N_MAT   = COLS * ROWS,
  localparam int unsigned N_KEYS  = N_MAT + SF,
  localparam int unsigned KEY_W   = $clog2(N_KEYS),
  localparam int unsigned GRP_W   = $clog2(COLS + 1),
  localparam int unsigned IDX_W   = $clog2(max_u(ROWS, SF))
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DWELL_W-1:0] dwell_i,
  input  logic [DEB_W-1:0]   debounce_i,
  input  logic [ROWS-1:0]    row_i,
  input  logic [SF-1:0]      sf_i,
  output logic [COLS-1:0]    col_o,
  input  logic               rd_i,
  input  logic               err_clr_i,
  output logic [KEY_W:0]     evt_o,
  output logic               evt_valid_o,
  output logic               fifo_ovr_o,
  output logic               key_ovr_o
);
  logic             eval, is_sf, raw;
  logic [GRP_W-1:0] grp;
  logic [IDX_W-1:0] idx;
  logic [KEY_W-1:0] key;
  logic             push_v, refuse, drop, fifo_empty, fifo_full;
  logic [KEY_W:0]   push_d;
  logic             fifo_ovr_q, key_ovr_q;

  kps_scan_seq #(.COLS(COLS), .ROWS(ROWS), .SF(SF), .DWELL_W(DWELL_W)) seq_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .dwell_i(dwell_i), .col_no(col_o),
    .eval_o(eval), .is_sf_o(is_sf), .grp_o(grp), .idx_o(idx)
  );

  assign raw = is_sf ? !sf_i[idx] : !row_i[idx];
  assign key = is_sf ? KEY_W'(N_MAT) + KEY_W'(idx)
                     : KEY_W'(grp) * KEY_W'(ROWS) + KEY_W'(idx);

  kps_debounce #(.N_KEYS(N_KEYS), .DEB_W(DEB_W), .MAX_DOWN(MAX_DOWN)) deb_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .eval_i(eval), .key_i(key), .raw_i(raw),
    .deb_i(debounce_i), .push_o(push_v), .evt_o(push_d), .refuse_o(refuse)
  );

  kps_evt_fifo #(.DEPTH(DEPTH), .W(KEY_W + 1)) fifo_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_v), .din_i(push_d),
    .pop_i(rd_i), .dout_o(evt_o), .empty_o(fifo_empty), .full_o(fifo_full),
    .drop_o(drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_ovr_q <= 1'b0;
      key_ovr_q  <= 1'b0;
    end else begin
      fifo_ovr_q <= (fifo_ovr_q && !err_clr_i) || drop;
      key_ovr_q  <= (key_ovr_q && !err_clr_i) || refuse;
    end
  end

  assign evt_valid_o = !fifo_empty;
  assign fifo_ovr_o  = fifo_ovr_q;
  assign key_ovr_o   = key_ovr_q;
endmodule

// File: rtl/keypad_scan_chk.sv
module keypad_scan_chk #(
  parameter int unsigned COLS = 8,
  parameter int unsigned EW   = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [COLS-1:0] col_o,
  input logic            rd_i,
  input logic            err_clr_i,
  input logic [EW-1:0]   evt_o,
  input logic            evt_valid_o,
  input logic            fifo_ovr_o,
  input logic            key_ovr_o,
  input logic            push_v,
  input logic            fifo_full
);
  a_r1_col_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~col_o) <= 1);

  a_r5_head_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o && !rd_i |=> evt_valid_o && $stable(evt_o));

  a_r7_drop_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full && push_v && !rd_i |=> fifo_ovr_o);

  a_r7_full_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full && !rd_i |=> fifo_full && $stable(evt_o));

  a_r9_fifo_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_ovr_o && !err_clr_i |=> fifo_ovr_o);

  a_r9_key_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_ovr_o && !err_clr_i |=> key_ovr_o);

  a_r9_fifo_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i && !(fifo_full && push_v && !rd_i) |=> !fifo_ovr_o);
endmodule

bind keypad_scan_top keypad_scan_chk #(.COLS(COLS), .EW(KEY_W + 1)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .col_o(col_o), .rd_i(rd_i),
  .err_clr_i(err_clr_i), .evt_o(evt_o), .evt_valid_o(evt_valid_o),
  .fifo_ovr_o(fifo_ovr_o), .key_ovr_o(key_ovr_o), .push_v(push_v),
  .fifo_full(fifo_full)
);

// File: tb/keypad_scan_top_tb_top.sv
module keypad_scan_top_tb_top;
  localparam int CLK_PER = 10;
  localparam int DWELL   = 2;
  localparam int SCAN    = 9 * (DWELL + 9);
  localparam logic [7:0] VEC [8] = '{8'h80, 8'h00, 8'hBF, 8'h3F,
                                      8'h9B, 8'hC7, 8'h1B, 8'h47};

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] dwell = 4'(DWELL), deb = 4'd3;
  logic [7:0] row, sf, col, evt;
  logic       rd = 1'b0, clr = 1'b0, vld, fovr, kovr;
  logic [63:0] mat_p = '0;
  logic [7:0]  sf_p = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  always_comb begin
    row = '1;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++)
        if (mat_p[c*8+r] && !col[c]) row[r] = 1'b0;
  end
  assign sf = ~sf_p;

  keypad_scan_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dwell_i(dwell), .debounce_i(deb),
    .row_i(row), .sf_i(sf), .col_o(col), .rd_i(rd), .err_clr_i(clr),
    .evt_o(evt), .evt_valid_o(vld), .fifo_ovr_o(fovr), .key_ovr_o(kovr)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_key(int k, bit p);
    if (k < 64) mat_p[k] = p;
    else sf_p[k-64] = p;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  // returns at the first negedge of a new scan (column 0 just driven)
  task automatic sync_scan();
    while (col != 8'hFF) @(negedge clk);
    while (col == 8'hFF) @(negedge clk);
  endtask

  task automatic expect_evt(string req, int exp);
    check({req, " valid"}, int'(vld), 1);
    check({req, " byte"}, int'(evt), exp);
    pop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] seen;
    int bad;
    wait_cyc(3);
    rst_n = 1'b1;
    // R10 reset state
    check("R10 col", int'(col), 8'hFE);
    check("R10 valid", int'(vld), 0);
    check("R10 fifo_ovr", int'(fovr), 0);
    check("R10 key_ovr", int'(kovr), 0);

    // R1 scan pattern and group length
    seen = '0; bad = 0;
    for (int i = 0; i < SCAN; i++) begin
      if (col == 8'hFF) seen[8] = 1'b1;
      else if ($countones(~col) == 1) begin
        for (int c = 0; c < 8; c++) if (!col[c]) seen[c] = 1'b1;
      end else bad++;
      @(negedge clk);
    end
    check("R1 patterns seen", int'(seen), 9'h1FF);
    check("R1 illegal patterns", bad, 0);
    sync_scan();
    wait_cyc(DWELL + 8);
    check("R1 column 0 held", int'(col), 8'hFE);
    wait_cyc(1);
    check("R1 column 1 next", int'(col), 8'hFD);

    // R3 debounce boundary
    set_key(10, 1'b1);
    wait_cyc((3 - 1) * SCAN);
    check("R3 not yet", int'(vld), 0);
    wait_cyc(SCAN);
    expect_evt("R3 accepted press", 8'h8A);
    set_key(10, 1'b0);
    wait_cyc((3 - 1) * SCAN);
    set_key(10, 1'b1);
    wait_cyc((3 - 1) * SCAN);
    check("R3 glitch ignored", int'(vld), 0);
    set_key(10, 1'b0);
    wait_cyc(3 * SCAN);
    expect_evt("R4 release", 8'h0A);
    check("R5 drained", int'(vld), 0);

    // table walk: R2 press, R4 release, R11 function keys
    for (int i = 0; i < 8; i++) begin
      string tag;
      tag = (VEC[i][6:0] >= 64) ? "R11" : (VEC[i][7] ? "R2" : "R4");
      set_key(int'(VEC[i][6:0]), VEC[i][7]);
      wait_cyc(3 * SCAN);
      expect_evt(tag, int'(VEC[i]));
      check("R5 single event", int'(vld), 0);
    end

    // R5 read on empty has no effect
    pop();
    check("R5 empty read", int'(vld), 0);
    set_key(5, 1'b1);
    wait_cyc(3 * SCAN);
    expect_evt("R5 after empty read", 8'h85);
    set_key(5, 1'b0);
    wait_cyc(3 * SCAN);
    expect_evt("R5 release", 8'h05);

    // R8 held-key limit, R6 order
    deb = 4'd1;
    sync_scan();
    for (int k = 0; k < 8; k++) set_key(k, 1'b1);
    wait_cyc(SCAN);
    for (int k = 0; k < 8; k++) expect_evt("R6 ascending press", 8'h80 | k);
    set_key(67, 1'b1);
    wait_cyc(SCAN);
    check("R8 refused no event", int'(vld), 0);
    check("R8 key_ovr set", int'(kovr), 1);
    sync_scan();
    set_key(3, 1'b0);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R9 key_ovr cleared", int'(kovr), 0);
    wait_cyc(SCAN - 1);
    expect_evt("R8 release first", 8'h03);
    expect_evt("R8 retried press", 8'hC3);
    check("R8 no new refusal", int'(kovr), 0);
    for (int k = 0; k < 8; k++) set_key(k, 1'b0);
    set_key(67, 1'b0);
    wait_cyc(SCAN);
    for (int k = 0; k < 8; k++) if (k != 3) expect_evt("R6 release order", k);
    expect_evt("R11 release", 8'h43);

    // R7 overflow
    sync_scan();
    for (int k = 8; k < 16; k++) set_key(k, 1'b1);
    wait_cyc(SCAN);
    for (int k = 8; k < 16; k++) set_key(k, 1'b0);
    wait_cyc(SCAN);
    check("R7 full no error yet", int'(fovr), 0);
    set_key(64, 1'b1);
    wait_cyc(SCAN);
    check("R7 overflow flag", int'(fovr), 1);
    for (int k = 8; k < 16; k++) expect_evt("R7 kept press", 8'h80 | k);
    for (int k = 8; k < 16; k++) expect_evt("R7 kept release", k);
    check("R7 dropped event", int'(vld), 0);
    check("R9 fifo_ovr sticky", int'(fovr), 1);
    set_key(64, 1'b0);
    wait_cyc(SCAN);
    expect_evt("R7 state followed drop", 8'h40);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R9 fifo_ovr cleared", int'(fovr), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule